// File: doc/BRIEF.md
# Structure Deinterleave and Interleave Permute Unit

This block is the permute stage between a 256-bit memory data path and a SIMD register file that has 64-bit vector registers. Memory bytes hold interleaved records of one to four members. On a load, member m of every record is gathered into vector register m. On a store, the lanes of up to four registers are woven back into memory order. The element width is 8, 16 or 32 bits and sets the lane count and the gather granularity. An endianness select controls how bytes inside an element are assembled. Two single-record modes handle one record on its own: one inserts it into a chosen lane and keeps the other lanes, and the other copies each member into every lane.

A command is a set of fields presented with `in_valid`. `in_ready` is high whenever the block is out of reset. All results are registered, and `out_valid` pulses exactly one cycle after a command is accepted. An illegal command raises `out_err` with that pulse and leaves every data output unchanged.

Top module: `struct_permute`

## Requirements
- R1: Memory byte b is `in_mem[8*b+7:8*b]`, and register lane i of element width E bytes is bits `[8*E*(i+1)-1 : 8*E*i]`. A multi-record load with N members (`in_count` = N-1) and width code w (0=8, 1=16, 2=32 bits, E = 1<<w) places memory element j = i*N+m into lane i of register m. For N=3 at 8 bits, register 0 receives bytes 0,3,6,...,21.
- R2: For a 2-member load at 16 bits, each register holds four elements. Register 0 takes the even-indexed elements and register 1 takes the odd-indexed ones.
- R3: For a 2-member load at 32 bits, 16 bytes are still consumed, but each register holds two elements, split into even and odd.
- R4: A multi-record store (`in_store`=1, `in_mode`=0) is the exact inverse of R1 for memory bytes 0..8N-1. Memory bytes from 8N upward are copied from `in_mem`.
- R5: A lane-insert load (`in_mode`=1) puts member m of the record at memory bytes [m*E, m*E+E) into lane `in_lane` of register m. Every other lane of that register is copied from the matching `in_reg`.
- R6: A broadcast load (`in_mode`=2) copies member m of the record at memory offset 0 into every lane of register m.
- R7: A lane store (`in_mode`=1) writes lane `in_lane` of register m to memory bytes [m*E, m*E+E) for each m < N. All other bytes are copied from `in_mem`.
- R8: With `in_big_end`=1, the lowest-addressed memory byte of an element is its most significant byte, in both directions. With `in_big_end`=0, it is the least significant byte.
- R9: On a load, registers m >= N are copied from their `in_reg` inputs, and `out_mem` keeps its previous value. On a store, every `out_reg` keeps its previous value.
- R10: `in_ready` is 1 out of reset. `out_valid` is 1 exactly in the cycle after an accepted command, and 0 otherwise.
- R11: These commands are illegal: width code 3, mode code 3, a lane mode with `in_lane` >= 8/E, and a broadcast store. An illegal command gives `out_err`=1 together with `out_valid`, and all data outputs keep their previous values. `out_err` is 0 for legal commands.
- R12: After reset, `out_valid`, `out_err`, `out_mem` and every `out_reg` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command can be accepted |
| in_store | input | 1 | 0 = load (memory to registers), 1 = store |
| in_mode | input | 2 | 0 multi-record, 1 lane insert, 2 broadcast, 3 illegal |
| in_count | input | 2 | Member count minus one |
| in_width | input | 2 | 0=8, 1=16, 2=32 bit elements, 3 illegal |
| in_lane | input | 3 | Lane index for lane mode |
| in_big_end | input | 1 | Byte order inside an element |
| in_mem | input | 256 | Memory-side bytes, byte 0 lowest |
| in_reg0 | input | 64 | Register 0 source / old contents |
| in_reg1 | input | 64 | Register 1 source / old contents |
| in_reg2 | input | 64 | Register 2 source / old contents |
| in_reg3 | input | 64 | Register 3 source / old contents |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Illegal command reported |
| out_mem | output | 256 | Store result bytes |
| out_reg0 | output | 64 | Load result register 0 |
| out_reg1 | output | 64 | Load result register 1 |
| out_reg2 | output | 64 | Load result register 2 |
| out_reg3 | output | 64 | Load result register 3 |

## Verification
The hardest cases to reach are the ones where several fields combine at their edges. Examples are a lane index one past the last lane at 32 bits, a 4-member 8-bit store that covers the whole memory word, and big-endian 16-bit data in lane mode. Uniform random stimulus rarely lands on those exact combinations. The stimulus therefore draws width, count, mode and lane independently from a fixed seed, with the lane drawn over its full 3-bit range so that out-of-range lanes appear often. Directed commands pin the known record layouts and the illegal encodings, and a load-then-store round trip confirms that the two permutations are inverses.

// File: rtl/spu_pkg.sv
package spu_pkg;

    localparam int BYTE_W    = 8;
    localparam int REG_BYTES = 8;
    localparam int NUM_REGS  = 4;
    localparam int MEM_BYTES = REG_BYTES * NUM_REGS;
    localparam int REG_W     = REG_BYTES * BYTE_W;
    localparam int MEM_W     = MEM_BYTES * BYTE_W;
    localparam int IDX_W     = $clog2(MEM_BYTES);
    localparam int RSEL_W    = $clog2(NUM_REGS);
    localparam int LANE_W    = $clog2(REG_BYTES);

    typedef enum logic [1:0] {
        MODE_MULTI = 2'd0,
        MODE_LANE  = 2'd1,
        MODE_BCAST = 2'd2,
        MODE_RSVD  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        WID_8    = 2'd0,
        WID_16   = 2'd1,
        WID_32   = 2'd2,
        WID_RSVD = 2'd3
    } width_e;

    typedef struct packed {
        logic              store;
        mode_e             mode;
        logic [1:0]        count;
        width_e            width;
        logic [LANE_W-1:0] lane;
        logic              big_end;
    } cmd_t;

    typedef logic [MEM_BYTES-1:0][BYTE_W-1:0]                mem_bytes_t;
    typedef logic [NUM_REGS-1:0][REG_BYTES-1:0][BYTE_W-1:0]  reg_file_t;

    // bytes per element for a width code
    function automatic int elem_bytes(width_e w);
        return 1 << int'(w);
    endfunction

    // which memory byte of an element feeds significance position k
    function automatic int byte_pos(int k, int eb, logic be);
        return be ? (eb - 1 - k) : k;
    endfunction

    function automatic int members(logic [1:0] cnt);
        return int'(cnt) + 1;
    endfunction

endpackage

// File: rtl/spu_cfg_check.sv
module spu_cfg_check
    import spu_pkg::*;
(
    input  cmd_t cmd,
    output logic cmd_err
);
    int lanes;

    always_comb begin
        lanes   = REG_BYTES >> int'(cmd.width);
        cmd_err = 1'b0;
        if (cmd.width == WID_RSVD)                                  cmd_err = 1'b1;
        if (cmd.mode == MODE_RSVD)                                  cmd_err = 1'b1;
        if (cmd.mode == MODE_LANE && int'(cmd.lane) >= lanes)       cmd_err = 1'b1;
        if (cmd.store && cmd.mode == MODE_BCAST)                    cmd_err = 1'b1;
    end

endmodule

// File: rtl/spu_load_path.sv
module spu_load_path
    import spu_pkg::*;
(
    input  cmd_t       cmd,
    input  mem_bytes_t mem,
    input  reg_file_t  regs_in,
    output reg_file_t  regs_out
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        int eb, n, lane_i, k, src;

        always_comb begin
            eb = elem_bytes(cmd.width);
            n  = members(cmd.count);
            for (int p = 0; p < REG_BYTES; p++) begin
                lane_i = p / eb;
                k      = byte_pos(p % eb, eb, cmd.big_end);
                src    = -1;
                if (g < n) begin
                    unique case (cmd.mode)
                        MODE_MULTI: src = (lane_i * n + g) * eb + k;
                        MODE_LANE:  src = (lane_i == int'(cmd.lane)) ? (g * eb + k) : -1;
                        MODE_BCAST: src = g * eb + k;
                        default:    src = -1;
                    endcase
                end
                if (src >= 0 && src < MEM_BYTES)
                    regs_out[g][p] = mem[IDX_W'(src)];
                else
                    regs_out[g][p] = regs_in[g][p];
            end
        end
    end

endmodule

// File: rtl/spu_store_path.sv
module spu_store_path
    import spu_pkg::*;
(
    input  cmd_t       cmd,
    input  mem_bytes_t mem_in,
    input  reg_file_t  regs,
    output mem_bytes_t mem_out
);
    int eb, n, j, k, src_r, src_b;

    always_comb begin
        eb = elem_bytes(cmd.width);
        n  = members(cmd.count);
        for (int b = 0; b < MEM_BYTES; b++) begin
            j     = b / eb;
            k     = byte_pos(b % eb, eb, cmd.big_end);
            src_r = -1;
            src_b = -1;
            unique case (cmd.mode)
                MODE_MULTI: if (b < n * REG_BYTES) begin
                    src_r = j % n;
                    src_b = (j / n) * eb + k;
                end
                MODE_LANE: if (b < n * eb) begin
                    src_r = j;
                    src_b = int'(cmd.lane) * eb + k;
                end
                default: ;
            endcase
            if (src_r >= 0 && src_r < NUM_REGS && src_b >= 0 && src_b < REG_BYTES)
                mem_out[b] = regs[RSEL_W'(src_r)][LANE_W'(src_b)];
            else
                mem_out[b] = mem_in[b];
        end
    end

endmodule

// File: rtl/struct_permute.sv
module struct_permute
    import spu_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         in_store,
    input  logic [1:0]   in_mode,
    input  logic [1:0]   in_count,
    input  logic [1:0]   in_width,
    input  logic [2:0]   in_lane,
    input  logic         in_big_end,
    input  logic [255:0] in_mem,
    input  logic [63:0]  in_reg0,
    input  logic [63:0]  in_reg1,
    input  logic [63:0]  in_reg2,
    input  logic [63:0]  in_reg3,
    output logic         out_valid,
    output logic         out_err,
    output logic [255:0] out_mem,
    output logic [63:0]  out_reg0,
    output logic [63:0]  out_reg1,
    output logic [63:0]  out_reg2,
    output logic [63:0]  out_reg3
);
    cmd_t       cmd;
    mem_bytes_t mem_in, mem_st;
    reg_file_t  regs_in, regs_ld, regs_q;
    mem_bytes_t mem_q;
    logic       cmd_err, accept, valid_q, err_q;

    assign cmd.store   = in_store;
    assign cmd.mode    = mode_e'(in_mode);
    assign cmd.count   = in_count;
    assign cmd.width   = width_e'(in_width);
    assign cmd.lane    = in_lane;
    assign cmd.big_end = in_big_end;

    assign mem_in     = in_mem;
    assign regs_in[0] = in_reg0;
    assign regs_in[1] = in_reg1;
    assign regs_in[2] = in_reg2;
    assign regs_in[3] = in_reg3;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;

    spu_cfg_check u_check (
        .cmd     (cmd),
        .cmd_err (cmd_err)
    );

    spu_load_path u_load (
        .cmd      (cmd),
        .mem      (mem_in),
        .regs_in  (regs_in),
        .regs_out (regs_ld)
    );

    spu_store_path u_store (
        .cmd     (cmd),
        .mem_in  (mem_in),
        .regs    (regs_in),
        .mem_out (mem_st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            mem_q   <= '0;
            regs_q  <= '0;
        end else begin
            valid_q <= accept;
            err_q   <= accept & cmd_err;
            if (accept && !cmd_err) begin
                if (cmd.store) mem_q  <= mem_st;
                else           regs_q <= regs_ld;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_err   = err_q;
    assign out_mem   = mem_q;
    assign out_reg0  = regs_q[0];
    assign out_reg1  = regs_q[1];
    assign out_reg2  = regs_q[2];
    assign out_reg3  = regs_q[3];

    // R10
    accept_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !out_valid);

    // R11
    err_freezes_data_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd_err) |=> ($stable(out_mem) && $stable(out_reg0) &&
            $stable(out_reg1) && $stable(out_reg2) && $stable(out_reg3) && out_err));

    // R9
    store_keeps_regs_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && in_store) |=> ($stable(out_reg0) && $stable(out_reg1) &&
            $stable(out_reg2) && $stable(out_reg3)));

    // R9
    load_keeps_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !in_store) |=> $stable(out_mem));

    // R9
    single_member_passes_reg3_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !in_store && !cmd_err && in_count == 2'd0) |=> (out_reg3 == $past(in_reg3)));

    // R11
    legal_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !cmd_err) |=> !out_err);

endmodule

// File: tb/struct_permute_tb.sv
module struct_permute_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_store = 1'b0;
    logic [1:0]   in_mode = '0, in_count = '0, in_width = '0;
    logic [2:0]   in_lane = '0;
    logic         in_big_end = 1'b0;
    logic [255:0] in_mem = '0;
    logic [63:0]  in_reg0 = '0, in_reg1 = '0, in_reg2 = '0, in_reg3 = '0;
    logic         out_valid, out_err;
    logic [255:0] out_mem;
    logic [63:0]  out_reg0, out_reg1, out_reg2, out_reg3;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [255:0] exp_mem = '0;
    logic [63:0]  exp_reg [4];
    logic         exp_err;

    always #2.5 clk = ~clk;

    struct_permute u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_store(in_store), .in_mode(in_mode), .in_count(in_count),
        .in_width(in_width), .in_lane(in_lane), .in_big_end(in_big_end),
        .in_mem(in_mem), .in_reg0(in_reg0), .in_reg1(in_reg1),
        .in_reg2(in_reg2), .in_reg3(in_reg3), .out_valid(out_valid),
        .out_err(out_err), .out_mem(out_mem), .out_reg0(out_reg0),
        .out_reg1(out_reg1), .out_reg2(out_reg2), .out_reg3(out_reg3)
    );

    task automatic check(input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // element value from memory bytes starting at byte a
    function automatic logic [31:0] rd_elem(input logic [255:0] m, input int a,
                                            input int e, input logic be);
        logic [31:0] v = '0;
        for (int k = 0; k < e; k++) begin
            if (be) v[(e-1-k)*8 +: 8] = m[(a+k)*8 +: 8];
            else    v[k*8 +: 8]       = m[(a+k)*8 +: 8];
        end
        return v;
    endfunction

    task automatic model();
        int e, n, lanes;
        logic [255:0] m;
        logic [63:0]  r [4];
        logic [31:0]  v;
        e = 1 << in_width;
        n = int'(in_count) + 1;
        lanes = 8 / e;
        r[0] = in_reg0; r[1] = in_reg1; r[2] = in_reg2; r[3] = in_reg3;
        exp_err = (in_width == 2'd3) || (in_mode == 2'd3) ||
                  (in_mode == 2'd1 && int'(in_lane) >= lanes) ||
                  (in_store && in_mode == 2'd2);
        if (exp_err) return;
        if (!in_store) begin
            for (int q = 0; q < 4; q++) exp_reg[q] = r[q];
            for (int mb = 0; mb < n; mb++)
                for (int s = 0; s < lanes; s++) begin
                    if (in_mode == 2'd0)
                        v = rd_elem(in_mem, (s*n+mb)*e, e, in_big_end);
                    else
                        v = rd_elem(in_mem, mb*e, e, in_big_end);
                    if (in_mode != 2'd1 || s == int'(in_lane))
                        for (int k = 0; k < e; k++)
                            exp_reg[mb][(s*e+k)*8 +: 8] = v[k*8 +: 8];
                end
        end else begin
            m = in_mem;
            for (int mb = 0; mb < n; mb++)
                for (int s = 0; s < lanes; s++) begin
                    if (in_mode == 2'd0 || s == int'(in_lane)) begin
                        int a;
                        v = '0;
                        for (int k = 0; k < e; k++) v[k*8 +: 8] = r[mb][(s*e+k)*8 +: 8];
                        a = (in_mode == 2'd0) ? (s*n+mb)*e : mb*e;
                        for (int k = 0; k < e; k++)
                            m[(a+k)*8 +: 8] = in_big_end ? v[(e-1-k)*8 +: 8] : v[k*8 +: 8];
                    end
                end
            exp_mem = m;
        end
    endtask

    task automatic run(input string req, input logic st, input logic [1:0] md,
                       input logic [1:0] cnt, input logic [1:0] wd, input logic [2:0] ln,
                       input logic be, input logic [255:0] mem,
                       input logic [63:0] r0, input logic [63:0] r1,
                       input logic [63:0] r2, input logic [63:0] r3);
        @(negedge clk);
        check("R10", "idle valid", {255'd0, out_valid}, 256'd0);
        in_store = st; in_mode = md; in_count = cnt; in_width = wd; in_lane = ln;
        in_big_end = be; in_mem = mem;
        in_reg0 = r0; in_reg1 = r1; in_reg2 = r2; in_reg3 = r3;
        in_valid = 1'b1;
        model();
        @(negedge clk);
        in_valid = 1'b0;
        check("R10", "valid", {255'd0, out_valid}, {255'd0, 1'b1});
        check(exp_err ? "R11" : req, "err", {255'd0, out_err}, {255'd0, exp_err});
        check(req, "mem", out_mem, exp_mem);
        check(req, "reg0", {192'd0, out_reg0}, {192'd0, exp_reg[0]});
        check(req, "reg1", {192'd0, out_reg1}, {192'd0, exp_reg[1]});
        check(req, "reg2", {192'd0, out_reg2}, {192'd0, exp_reg[2]});
        check(req, "reg3", {192'd0, out_reg3}, {192'd0, exp_reg[3]});
    endtask

    function automatic logic [255:0] ramp();
        logic [255:0] m;
        for (int b = 0; b < 32; b++) m[b*8 +: 8] = 8'(b);
        return m;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [255:0] m0;
        logic [63:0] a0, a1, a2, a3;
        process::self().srandom(32'h5EED_1234);
        for (int q = 0; q < 4; q++) exp_reg[q] = '0;
        m0 = ramp();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12", "reset valid/err", {254'd0, out_valid, out_err}, 256'd0);
        check("R12", "reset mem", out_mem, 256'd0);
        check("R12", "reset regs", {out_reg0, out_reg1, out_reg2, out_reg3}, 256'd0);
        check("R10", "ready", {255'd0, in_ready}, {255'd0, 1'b1});

        // R1 three 8-bit members
        run("R1", 0, 2'd0, 2'd2, 2'd0, 3'd0, 0, m0, '0, '0, '0, 64'hAAAA);
        check("R1", "rgb reg0 literal", {192'd0, out_reg0}, {192'd0, 64'h1512_0F0C_0906_0300});
        check("R1", "rgb reg2 literal", {192'd0, out_reg2}, {192'd0, 64'h1714_110E_0B08_0502});
        check("R9", "reg3 pass", {192'd0, out_reg3}, {192'd0, 64'hAAAA});
        // R2 two 16-bit members
        run("R2", 0, 2'd0, 2'd1, 2'd1, 3'd0, 0, m0, '0, '0, '0, '0);
        check("R2", "even literal", {192'd0, out_reg0}, {192'd0, 64'h0D0C_0908_0504_0100});
        // R3 two 32-bit members
        run("R3", 0, 2'd0, 2'd1, 2'd2, 3'd0, 0, m0, '0, '0, '0, '0);
        check("R3", "even literal", {192'd0, out_reg0}, {192'd0, 64'h0B0A_0908_0302_0100});
        // R8 big-endian 16-bit
        run("R8", 0, 2'd0, 2'd1, 2'd1, 3'd0, 1, m0, '0, '0, '0, '0);
        check("R8", "swapped literal", {192'd0, out_reg0}, {192'd0, 64'h0C0D_0809_0405_0001});
        // R5 lane insert, last 16-bit lane, big endian
        run("R5", 0, 2'd1, 2'd3, 2'd1, 3'd3, 1, m0,
            64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222,
            64'h3333_3333_3333_3333, 64'h4444_4444_4444_4444);
        check("R5", "lane literal", {192'd0, out_reg0}, {192'd0, 64'h0001_1111_1111_1111});
        // R6 broadcast 32-bit
        run("R6", 0, 2'd2, 2'd1, 2'd2, 3'd0, 0, m0, '0, '0, '0, '0);
        check("R6", "bcast literal", {192'd0, out_reg1}, {192'd0, 64'h0706_0504_0706_0504});
        // R4 round trip: store the registers loaded by a 4x8 load
        run("R1", 0, 2'd0, 2'd3, 2'd0, 3'd0, 0, m0, '0, '0, '0, '0);
        a0 = out_reg0; a1 = out_reg1; a2 = out_reg2; a3 = out_reg3;
        run("R4", 1, 2'd0, 2'd3, 2'd0, 3'd0, 0, '0, a0, a1, a2, a3);
        check("R4", "round trip", out_mem, m0);
        // R4 partial store keeps upper bytes
        run("R4", 1, 2'd0, 2'd0, 2'd1, 3'd0, 0, {256{1'b1}}, 64'h0123_4567_89AB_CDEF, '0, '0, '0);
        // R7 lane store
        run("R7", 1, 2'd1, 2'd2, 2'd2, 3'd1, 1, {256{1'b1}}, rnd64(), rnd64(), rnd64(), rnd64());
        // R11 illegal commands
        run("R11", 0, 2'd1, 2'd0, 2'd2, 3'd2, 0, rnd256(), rnd64(), '0, '0, '0);
        run("R11", 1, 2'd2, 2'd0, 2'd0, 3'd0, 0, rnd256(), rnd64(), '0, '0, '0);
        run("R11", 0, 2'd0, 2'd0, 2'd3, 3'd0, 0, rnd256(), rnd64(), '0, '0, '0);
        run("R11", 1, 2'd3, 2'd0, 2'd0, 3'd0, 0, rnd256(), rnd64(), '0, '0, '0);

        // random mix
        for (int t = 0; t < 400; t++) begin
            logic st;
            logic [1:0] md, wd;
            string tag;
            st = 1'($urandom);
            md = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
            wd = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
            if (st) tag = (md == 2'd1) ? "R7" : "R4";
            else    tag = (md == 2'd1) ? "R5" : (md == 2'd2) ? "R6" : "R1";
            run(tag, st, md, 2'($urandom), wd, 3'($urandom), 1'($urandom),
                rnd256(), rnd64(), rnd64(), rnd64(), rnd64());
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule